// File: doc/BRIEF.md
# Resolver Converter Sample-and-Read Sequencer

This block is the master side of the read path to a resolver-to-digital converter that has a serial output. A request on a ready/valid handshake chooses angle or velocity. The block then runs one read sequence. It first pulls a sample strobe low, which freezes the converter's position and velocity registers. When the strobe goes high again, the block drives a select line that tells the converter which quantity to present. It then clocks in one 16-bit frame over an SPI link in mode 3.

The upper twelve bits of the frame are the measurement and the last four bits are dropped. An angle is returned as an unsigned number. A velocity is returned as a two's-complement number, sign-extended to the output width.

After chip select is released, the block holds off new requests for a guard interval. Only one sequence is ever in flight. The SCLK divider and the strobe and guard intervals come from parameters given in system-clock cycles and nanoseconds. Each interval is rounded up so that its minimum time is always met.

Top module: `rslv_sampler`

## Requirements
- R1: While reset is applied: `sampleN` is 0, `selAngle` is 0, `spiCsN` is 1, `spiSclk` is 1 and `resValid` is 0. After reset, `reqReady` is 1 and `sampleN` returns to 1.
- R2: Each accepted request produces exactly one low pulse on `sampleN`. The pulse lasts at least 6 SCLK periods plus 20 ns, and `spiCsN` stays high for the whole pulse.
- R3: After the strobe goes high and before `spiCsN` falls, `selAngle` is set to the latched request channel: 1 selects angle and 0 selects velocity. It does not change while `spiCsN` is low. `reqAngle` is ignored after acceptance.
- R4: The SPI link runs in mode 3. `spiSclk` is high when `spiCsN` falls and when it rises. Exactly 16 rising edges occur while `spiCsN` is low, and the SCLK period is 2*SCLK_HALF system clocks.
- R5: `spiMiso` is sampled on the rising SCLK edges, most-significant bit first. The result field is bits 15..4 of the received frame, and bits 3..0 have no effect.
- R6: For an angle read (`reqAngle`=1), `resData` holds the 12-bit field zero-extended to OUT_W bits.
- R7: For a velocity read (`reqAngle`=0), `resData` holds the 12-bit field sign-extended from field bit 11 (frame bit 15) to OUT_W bits.
- R8: `resValid` is high for exactly one cycle per request, in the same cycle in which `spiCsN` returns high.
- R9: `reqReady` stays low from acceptance until at least 2 SCLK periods plus 20 ns after `spiCsN` rises.
- R10: A request made while the block is busy sees `reqReady` low, is not accepted and starts no sequence. It is served once `reqReady` rises, provided `reqValid` is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request |
| reqAngle | input | 1 | Channel of the request: 1 for angle, 0 for velocity |
| reqReady | output | 1 | High when a request can be accepted |
| sampleN | output | 1 | Active-low sample-freeze strobe to the converter |
| selAngle | output | 1 | Quantity select to the converter: high for angle |
| spiSclk | output | 1 | SPI clock, idles high |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMiso | input | 1 | SPI serial data from the converter |
| resValid | output | 1 | One-cycle pulse marking a new result |
| resData | output | OUT_W | Result, zero- or sign-extended according to channel |

## Verification
A slave model shifts out queued frames, and a scoreboard compares each result with a value computed from the frame and the channel.

The frames are chosen to separate the cases the requirements describe:
- All-ones frames read as angle and as velocity. The only difference between the two results is the extension rule.
- The positive and negative velocity extremes (0x7FF and 0x800) exercise the sign bit.
- A frame with non-zero low bits shows that those bits are discarded.
- Alternating bit patterns show MSB-first order.

Back-to-back requests, with the channel input flipped after acceptance, show that requests are held off and that the channel is latched. The strobe width, the guard interval and the SCLK period are timed against their nanosecond minimums.

// File: rtl/rslv_pkg.sv
`timescale 1ns/1ps
package rslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_SELECT,
    ST_XFER,
    ST_TAIL,
    ST_GUARD
  } rslvState_t;

  typedef struct packed {
    logic clear;
    logic shift;
    logic load;
    logic isAngle;
  } rslvStrobe_t;

  function automatic int ceilCycles(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

endpackage

// File: rtl/rslv_ctrl.sv
`timescale 1ns/1ps
module rslv_ctrl
  import rslv_pkg::*;
#(
  parameter int CLK_NS    = 5,
  parameter int SCLK_HALF = 13,
  parameter int FRAME_W   = 16,
  parameter int MARGIN_NS = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqAngle,
  output logic        reqReady,
  output logic        sampleN,
  output logic        selAngle,
  output logic        spiSclk,
  output logic        spiCsN,
  output rslvStrobe_t strb
);

  localparam int SCLK_NS    = 2 * SCLK_HALF * CLK_NS;
  localparam int STROBE_CYC = ceilCycles(6 * SCLK_NS + MARGIN_NS, CLK_NS);
  localparam int GUARD_CYC  = ceilCycles(2 * SCLK_NS + MARGIN_NS, CLK_NS);
  localparam int MAX_CYC    = (STROBE_CYC > GUARD_CYC) ?
                              ((STROBE_CYC > SCLK_HALF) ? STROBE_CYC : SCLK_HALF) :
                              ((GUARD_CYC > SCLK_HALF) ? GUARD_CYC : SCLK_HALF);
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int BIT_W      = $clog2(FRAME_W + 1);

  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] GUARD_LD  = CNT_W'(GUARD_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LD   = CNT_W'(SCLK_HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

  rslvState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic             chanAngle;
  logic             cntDone;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitCnt    <= '0;
      chanAngle <= 1'b0;
      sampleN   <= 1'b0;
      selAngle  <= 1'b0;
      spiSclk   <= 1'b1;
      spiCsN    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          sampleN <= 1'b1;
          if (reqValid) begin
            chanAngle <= reqAngle;
            sampleN   <= 1'b0;
            cnt       <= STROBE_LD;
            state     <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (cntDone) begin
            sampleN  <= 1'b1;
            selAngle <= chanAngle;
            cnt      <= HALF_LD;
            state    <= ST_SELECT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SELECT: begin
          if (cntDone) begin
            spiCsN  <= 1'b0;
            spiSclk <= 1'b1;
            bitCnt  <= '0;
            cnt     <= HALF_LD;
            state   <= ST_XFER;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_XFER: begin
          if (cntDone) begin
            cnt     <= HALF_LD;
            spiSclk <= ~spiSclk;
            if (!spiSclk) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) state <= ST_TAIL;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (cntDone) begin
            spiCsN <= 1'b1;
            cnt    <= GUARD_LD;
            state  <= ST_GUARD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GUARD: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strb.clear   = (state == ST_IDLE) && reqValid;
  assign strb.shift   = (state == ST_XFER) && cntDone && !spiSclk;
  assign strb.load    = (state == ST_TAIL) && cntDone;
  assign strb.isAngle = chanAngle;

  AST_CS_EDGE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(spiCsN) || $fell(spiCsN)) |-> spiSclk) else $error("cs edge with sclk low"); // R4
  AST_STROBE_NO_XFER: assert property (@(posedge clk) disable iff (!rstN)
    !sampleN |-> spiCsN) else $error("strobe overlaps transfer"); // R2
  AST_SEL_STABLE_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && $past(!spiCsN)) |-> $stable(selAngle)) else $error("select moved in transfer"); // R3
  AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_W'(FRAME_W)) else $error("bit count overflow"); // R4
  AST_STROBE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampleN) |-> $past(reqValid && reqReady)) else $error("strobe without accept"); // R10

endmodule

// File: rtl/rslv_dpath.sv
`timescale 1ns/1ps
module rslv_dpath
  import rslv_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int RES_W   = 12,
  parameter int OUT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rslvStrobe_t      strb,
  input  logic             spiMiso,
  output logic             resValid,
  output logic [OUT_W-1:0] resData
);

  localparam int PAD_W = OUT_W - RES_W;

  logic [FRAME_W-1:0] shReg;
  logic [RES_W-1:0]   field;
  logic [OUT_W-1:0]   extended;

  assign field = shReg[FRAME_W-1 -: RES_W];

  generate
    if (PAD_W > 0) begin : g_pad
      logic padBit;
      assign padBit   = field[RES_W-1] & ~strb.isAngle;
      assign extended = {{PAD_W{padBit}}, field};
    end else begin : g_nopad
      assign extended = field;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      resValid <= 1'b0;
      resData  <= '0;
    end else begin
      if (strb.clear)      shReg <= '0;
      else if (strb.shift) shReg <= {shReg[FRAME_W-2:0], spiMiso};
      resValid <= strb.load;
      if (strb.load) resData <= extended;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid) else $error("valid longer than one cycle"); // R8
  AST_NO_SHIFT_AT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shift && strb.load)) else $error("shift and load together"); // R5

endmodule

// File: rtl/rslv_sampler.sv
`timescale 1ns/1ps
module rslv_sampler
  import rslv_pkg::*;
#(
  parameter int CLK_NS    = 5,
  parameter int SCLK_HALF = 13,
  parameter int FRAME_W   = 16,
  parameter int RES_W     = 12,
  parameter int OUT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqAngle,
  output logic             reqReady,
  output logic             sampleN,
  output logic             selAngle,
  output logic             spiSclk,
  output logic             spiCsN,
  input  logic             spiMiso,
  output logic             resValid,
  output logic [OUT_W-1:0] resData
);

  rslvStrobe_t strb;

  rslv_ctrl #(
    .CLK_NS(CLK_NS), .SCLK_HALF(SCLK_HALF), .FRAME_W(FRAME_W), .MARGIN_NS(20)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAngle(reqAngle),
    .reqReady(reqReady), .sampleN(sampleN), .selAngle(selAngle),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .strb(strb)
  );

  rslv_dpath #(
    .FRAME_W(FRAME_W), .RES_W(RES_W), .OUT_W(OUT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .spiMiso(spiMiso),
    .resValid(resValid), .resData(resData)
  );

endmodule

// File: tb/rslv_sampler_tb.sv
`timescale 1ns/1ps
module rslv_sampler_tb;

  localparam int  HALF    = 13;
  localparam real SCLK_NS = 2.0 * HALF * 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqAngle = 1'b0;
  logic spiMiso = 1'b0;
  logic reqReady, sampleN, selAngle, spiSclk, spiCsN, resValid;
  logic [15:0] resData;

  int checks = 0;
  int failures = 0;
  int issued = 0;
  int strobes = 0;
  int results = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  logic [15:0] frameQ[$];
  logic        chanQ[$];
  logic [15:0] curFrame;
  logic        curChan;
  int          bitIdx;
  int          rises;
  realtime     tStrobe, tCsRise, tLastRise;
  bit          periodChecked = 1'b0;
  bit          prevReady = 1'b1;
  bit          prevValid = 1'b0;

  always #2.5 clk = ~clk;

  rslv_sampler #(.CLK_NS(5), .SCLK_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAngle(reqAngle),
    .reqReady(reqReady), .sampleN(sampleN), .selAngle(selAngle),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMiso(spiMiso),
    .resValid(resValid), .resData(resData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe timing and overlap: R2
  always @(negedge sampleN) if (rstN) begin
    tStrobe = $realtime;
    strobes++;
  end
  always @(posedge sampleN) if (rstN && strobes > 0) begin
    check(($realtime - tStrobe) >= 6.0 * SCLK_NS + 20.0, "R2 strobe width ns",
          int'($realtime - tStrobe), int'(6.0 * SCLK_NS + 20.0));
  end
  always @(negedge clk) if (rstN && !sampleN && strobes > 0)
    if (!spiCsN) check(1'b0, "R2 cs low during strobe", 0, 1);

  // select changes only with cs high: R3
  always @(selAngle) if (rstN)
    check(spiCsN && sampleN, "R3 select moved outside window", {spiCsN, sampleN}, 2'b11);

  // slave model, mode 3
  always @(negedge spiCsN) begin
    curFrame = frameQ.size() > 0 ? frameQ.pop_front() : 16'h0;
    curChan  = chanQ.size() > 0 ? chanQ.pop_front() : 1'b0;
    bitIdx = 15;
    rises = 0;
    check(spiSclk == 1'b1, "R4 sclk high at cs fall", spiSclk, 1);
    check(selAngle == curChan, "R3 select level at cs fall", selAngle, curChan);
    check(sampleN == 1'b1, "R2 strobe released before transfer", sampleN, 1);
  end
  always @(negedge spiSclk) if (!spiCsN) begin
    spiMiso <= (bitIdx >= 0) ? curFrame[bitIdx] : 1'b0;
    bitIdx--;
  end
  always @(posedge spiSclk) if (!spiCsN) begin
    if (rises > 0 && !periodChecked) begin
      periodChecked = 1'b1;
      check(($realtime - tLastRise) == SCLK_NS, "R4 sclk period ns",
            int'($realtime - tLastRise), int'(SCLK_NS));
    end
    tLastRise = $realtime;
    rises++;
  end
  always @(posedge spiCsN) if (rstN) begin
    tCsRise = $realtime;
    check(rises == 16, "R4 rising edges per frame", rises, 16);
    check(spiSclk == 1'b1, "R4 sclk high at cs rise", spiSclk, 1);
  end

  // scoreboard monitor and guard: R8, R9
  always @(negedge clk) if (rstN) begin
    if (resValid) begin
      results++;
      check(!prevValid, "R8 valid single cycle", prevValid, 0);
      check(spiCsN == 1'b1, "R8 valid with cs released", spiCsN, 1);
      if (expQ.size() == 0) check(1'b0, "R8 unexpected result", resData, 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check(resData == e, "R5 R6 R7 result value", resData, e);
      end
    end
    if (reqReady && !prevReady)
      check(($realtime - tCsRise) >= 2.0 * SCLK_NS + 20.0, "R9 guard ns",
            int'($realtime - tCsRise), int'(2.0 * SCLK_NS + 20.0));
    prevReady = reqReady;
    prevValid = resValid;
  end

  function automatic logic [15:0] expect_of(input logic ang, input logic [15:0] f);
    return ang ? {4'h0, f[15:4]} : {{4{f[15]}}, f[15:4]};
  endfunction

  // driver: pushes expectation, waits for ready, flips channel after accept
  task automatic issue(input logic ang, input logic [15:0] f, input bit hold);
    @(negedge clk);
    expQ.push_back(expect_of(ang, f));
    frameQ.push_back(f);
    chanQ.push_back(ang);
    reqValid = 1'b1;
    reqAngle = ang;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    issued++;
    reqAngle = ~ang;
    check(reqReady == 1'b0, "R9 ready low after accept", reqReady, 0);
    if (!hold) reqValid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(reqReady && expQ.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sampleN == 1'b0, "R1 reset sample", sampleN, 0);
    check(selAngle == 1'b0, "R1 reset select", selAngle, 0);
    check(spiCsN == 1'b1, "R1 reset cs", spiCsN, 1);
    check(spiSclk == 1'b1, "R1 reset sclk", spiSclk, 1);
    check(resValid == 1'b0, "R1 reset valid", resValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(sampleN == 1'b1, "R1 sample idle high", sampleN, 1);

    issue(1'b1, 16'hFFF0, 1'b0); wait_idle();   // R6 all ones angle
    issue(1'b0, 16'hFFF0, 1'b0); wait_idle();   // R7 all ones velocity
    issue(1'b0, 16'h7FF0, 1'b0); wait_idle();   // R7 max positive
    issue(1'b0, 16'h8000, 1'b0); wait_idle();   // R7 max negative
    issue(1'b1, 16'h800F, 1'b0); wait_idle();   // R5 low bits dropped
    issue(1'b1, 16'hA5A5, 1'b0); wait_idle();   // R5 MSB first
    issue(1'b0, 16'h5A5F, 1'b0); wait_idle();
    issue(1'b1, 16'h0000, 1'b0); wait_idle();

    // R10: back-to-back, second request held while busy
    issue(1'b1, 16'h1230, 1'b1);
    repeat (20) @(negedge clk);
    check(reqReady == 1'b0, "R10 ready low while busy", reqReady, 0);
    check(strobes == issued, "R10 no extra strobe while busy", strobes, issued);
    issue(1'b0, 16'hC3C0, 1'b0);
    wait_idle();

    check(strobes == issued, "R2 one strobe per request", strobes, issued);
    check(results == issued, "R8 one result per request", results, issued);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", results, issued);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule